// File: doc/BRIEF.md
# Two-Wire Bus Idle Detector and Arbitration Watch

This block tells a two-wire bus master when it may claim the bus, and it notices when the master has lost arbitration to another master. It reads the SCL and SDA levels after they have been synchronized to the system clock. Before a start or a repeated start, it requires both lines to stay high for a programmed number of clock periods. Two 12-bit counts are held, one for standard speed and one for fast speed. If either line goes low during the wait, the count starts again from zero.

Once the sequencer reports that the start has gone out, the block stops granting the bus on its own. Retrying from that point is left to the host. While the master sends address or write bits, the block compares each released bit with the level seen on SDA while SCL is high. It makes the same check in the acknowledge slot of a burst read, where the master means to send a NACK. A mismatch sets a sticky bus-loss flag and gives a one-cycle abort pulse. It also tells the pad logic to release both lines. The flag stays set until the host clears it or issues a new command.

All pins are plain control and status signals sampled on the rising clock edge. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `i2c_arb_monitor`

## Requirements
- R1: With `claim_req` high and both lines high, `bus_free` goes high once L rising edges have been counted since the count last restarted, where L is the selected limit. A limit of 0 grants at once while both lines are high.
- R2: A low level on SCL or SDA during the wait restarts the count. L further edges with both lines high are then needed before `bus_free` rises.
- R3: `speed_fast` = 1 selects `free_cnt_fast` as L, and 0 selects `free_cnt_std`. Both are 12-bit unsigned cycle counts.
- R4: A `start_issued` pulse while `claim_req` is high keeps `bus_free` low from the next cycle on. This lasts until `claim_req` has gone low and been raised again, after which a fresh full count is needed.
- R5: With `tx_phase` high, `drv_bit` = 1 (released) and SCL high, an SDA low sets `bus_loss` after the next rising edge.
- R6: A driven-low bit (`drv_bit` = 0) never causes bus loss. No comparison is made while SCL is low.
- R7: With `nack_slot` high and SCL high, an SDA low (an ACK from another device) sets `bus_loss` after the next rising edge.
- R8: `abort_pulse` is high for exactly one cycle, in the cycle in which `bus_loss` first becomes high.
- R9: `bus_loss` stays high until `loss_clr` or `cmd_new` is sampled high. While it is high, `release_lines` is high and `bus_free` is low.
- R10: During and just after reset, `bus_free`, `bus_loss`, `abort_pulse` and `release_lines` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| speed_fast | input | 1 | 1 selects the fast-speed bus-free count |
| free_cnt_std | input | 12 | Bus-free count for standard speed |
| free_cnt_fast | input | 12 | Bus-free count for fast speed |
| claim_req | input | 1 | Sequencer wants the bus for a start or repeated start |
| start_issued | input | 1 | Pulse: the start has been placed on the bus |
| tx_phase | input | 1 | Address or write-data bits are being sent |
| drv_bit | input | 1 | Bit the master drives (1 = released) |
| nack_slot | input | 1 | Acknowledge slot of a burst read in which a NACK is intended |
| loss_clr | input | 1 | Host clears the bus-loss flag |
| cmd_new | input | 1 | Host issues a new command (also clears the flag) |
| bus_free | output | 1 | Grant: the bus may be claimed |
| bus_loss | output | 1 | Sticky arbitration-loss status |
| abort_pulse | output | 1 | One-cycle abort/interrupt on bus loss |
| release_lines | output | 1 | Request to release SCL and SDA |

## Verification
`bus_free` is combinational over a registered count. After `claim_req` rises with both lines high, it is first seen high after the L-th rising edge. The bench checks it low after L-1 edges and high after L. `bus_loss`, `abort_pulse` and `release_lines` become valid one rising edge after the offending sample, and the abort is checked gone one edge later. The bench drives all stimulus on the falling edge and samples every output on a later falling edge, so each check sits a whole number of rising edges after its stimulus.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  localparam int unsigned FREE_CNT_W = 12;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lvl_t;
endpackage

// File: rtl/arb_busfree_timer.sv
module arb_busfree_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lines_high,
  input  logic [CNT_W-1:0] limit,
  output logic             free
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  // restart on any low level or when not waiting; saturate at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!en || !lines_high) cnt <= '0;
    else if (cnt != CNT_MAX)     cnt <= cnt + 1'b1;
  end

  assign free = en && lines_high && (cnt >= limit);

  AST_FREE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (free && limit != '0) |-> $past(lines_high && en)); // R1
  AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lines_high) |=> (cnt == '0)); // R2
endmodule

// File: rtl/arb_bit_compare.sv
module arb_bit_compare (
  input  logic scl,
  input  logic sda,
  input  logic armed,
  input  logic tx_phase,
  input  logic drv_bit,
  input  logic nack_slot,
  output logic mismatch
);
  logic expect_high;

  // a released bit (data 1 or intended NACK) must read back high
  always_comb begin
    expect_high = (tx_phase && drv_bit) || nack_slot;
    mismatch    = armed && scl && !sda && expect_high;
  end
endmodule

// File: rtl/arb_loss_flag.sv
module arb_loss_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch,
  input  logic clr,
  output logic bus_loss,
  output logic abort_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_loss    <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= !bus_loss && mismatch;
      if (bus_loss && clr)        bus_loss <= 1'b0;
      else if (!bus_loss && mismatch) bus_loss <= 1'b1;
    end
  end

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse); // R8
  AST_ABORT_WITH_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> bus_loss); // R8
  AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_loss && !clr) |=> bus_loss); // R9
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor #(
  parameter int unsigned CNT_W = i2c_arb_pkg::FREE_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             speed_fast,
  input  logic [CNT_W-1:0] free_cnt_std,
  input  logic [CNT_W-1:0] free_cnt_fast,
  input  logic             claim_req,
  input  logic             start_issued,
  input  logic             tx_phase,
  input  logic             drv_bit,
  input  logic             nack_slot,
  input  logic             loss_clr,
  input  logic             cmd_new,
  output logic             bus_free,
  output logic             bus_loss,
  output logic             abort_pulse,
  output logic             release_lines
);
  import i2c_arb_pkg::*;

  bus_lvl_t         lvl;
  logic [CNT_W-1:0] limit;
  logic             committed;
  logic             wait_en;
  logic             mismatch;

  assign lvl   = '{scl: scl_i, sda: sda_i};
  assign limit = speed_fast ? free_cnt_fast : free_cnt_std;

  // no automatic retry once the start is out; re-armed when claim drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            committed <= 1'b0;
    else if (!claim_req)   committed <= 1'b0;
    else if (start_issued) committed <= 1'b1;
  end

  assign wait_en = claim_req && !committed && !bus_loss;

  arb_busfree_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (wait_en),
    .lines_high (lvl.scl && lvl.sda),
    .limit      (limit),
    .free       (bus_free)
  );

  arb_bit_compare u_cmp (
    .scl       (lvl.scl),
    .sda       (lvl.sda),
    .armed     (!bus_loss),
    .tx_phase  (tx_phase),
    .drv_bit   (drv_bit),
    .nack_slot (nack_slot),
    .mismatch  (mismatch)
  );

  arb_loss_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .mismatch    (mismatch),
    .clr         (loss_clr || cmd_new),
    .bus_loss    (bus_loss),
    .abort_pulse (abort_pulse)
  );

  assign release_lines = bus_loss;

  AST_NO_AUTO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_issued && claim_req) |=> !bus_free); // R4
  AST_RELEASED_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_loss && tx_phase && drv_bit && scl_i && !sda_i) |=> bus_loss); // R5
  AST_LOW_BIT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_loss && tx_phase && !drv_bit && !nack_slot) |=> !bus_loss); // R6
  AST_NACK_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_loss && nack_slot && scl_i && !sda_i) |=> bus_loss); // R7
  AST_LOST_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_loss |-> !bus_free); // R9
endmodule

// File: tb/test_i2c_arb_monitor.sv
module test_i2c_arb_monitor;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, speed_fast = 1'b0;
  logic [11:0] free_cnt_std = 12'd5, free_cnt_fast = 12'd2;
  logic claim_req = 0, start_issued = 0, tx_phase = 0, drv_bit = 1;
  logic nack_slot = 0, loss_clr = 0, cmd_new = 0;
  logic bus_free, bus_loss, abort_pulse, release_lines;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_arb_monitor i_i2c_arb_monitor (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .speed_fast(speed_fast), .free_cnt_std(free_cnt_std),
    .free_cnt_fast(free_cnt_fast), .claim_req(claim_req),
    .start_issued(start_issued), .tx_phase(tx_phase), .drv_bit(drv_bit),
    .nack_slot(nack_slot), .loss_clr(loss_clr), .cmd_new(cmd_new),
    .bus_free(bus_free), .bus_loss(bus_loss), .abort_pulse(abort_pulse),
    .release_lines(release_lines)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_all();
    claim_req = 0; tx_phase = 0; nack_slot = 0; drv_bit = 1;
    scl_i = 1; sda_i = 1; start_issued = 0; loss_clr = 0; cmd_new = 0;
    edges(1);
  endtask

  task automatic t_reset();
    chk("R10", "bus_free", bus_free, 1'b0);
    chk("R10", "bus_loss", bus_loss, 1'b0);
    chk("R10", "abort_pulse", abort_pulse, 1'b0);
    chk("R10", "release_lines", release_lines, 1'b0);
  endtask

  task automatic t_std_count();
    speed_fast = 0; free_cnt_std = 12'd5; claim_req = 1;
    edges(4);
    chk("R1", "free early", bus_free, 1'b0);
    edges(1);
    chk("R1", "free at limit", bus_free, 1'b1);
    idle_all();
  endtask

  task automatic t_fast_count();
    speed_fast = 1; free_cnt_fast = 12'd2; claim_req = 1;
    edges(1);
    chk("R3", "fast early", bus_free, 1'b0);
    edges(1);
    chk("R3", "fast at limit", bus_free, 1'b1);
    speed_fast = 0;
    idle_all();
  endtask

  task automatic t_restart();
    free_cnt_std = 12'd6; claim_req = 1;
    edges(4);
    sda_i = 0;
    edges(1);
    sda_i = 1;
    edges(5);
    chk("R2", "free after sda low", bus_free, 1'b0);
    edges(1);
    chk("R2", "free after full recount", bus_free, 1'b1);
    scl_i = 0;
    edges(1);
    scl_i = 1;
    chk("R2", "free after scl low", bus_free, 1'b0);
    idle_all();
  endtask

  task automatic t_no_retry();
    free_cnt_std = 12'd3; claim_req = 1;
    edges(3);
    chk("R4", "granted", bus_free, 1'b1);
    start_issued = 1;
    edges(1);
    start_issued = 0;
    chk("R4", "after start", bus_free, 1'b0);
    edges(10);
    chk("R4", "still no retry", bus_free, 1'b0);
    claim_req = 0;
    edges(1);
    claim_req = 1;
    edges(2);
    chk("R4", "rearmed early", bus_free, 1'b0);
    edges(1);
    chk("R4", "rearmed grant", bus_free, 1'b1);
    idle_all();
  endtask

  task automatic t_tx_mismatch();
    claim_req = 1; tx_phase = 1; drv_bit = 1; scl_i = 1; sda_i = 0;
    edges(1);
    chk("R5", "loss set", bus_loss, 1'b1);
    chk("R8", "abort pulse", abort_pulse, 1'b1);
    chk("R9", "release", release_lines, 1'b1);
    edges(1);
    chk("R8", "abort one cycle", abort_pulse, 1'b0);
    tx_phase = 0; sda_i = 1;
    edges(4);
    chk("R9", "loss held", bus_loss, 1'b1);
    chk("R9", "no grant while lost", bus_free, 1'b0);
    loss_clr = 1;
    edges(1);
    loss_clr = 0;
    chk("R9", "cleared by host", bus_loss, 1'b0);
    chk("R9", "release dropped", release_lines, 1'b0);
    idle_all();
  endtask

  task automatic t_low_bit();
    tx_phase = 1; drv_bit = 0; scl_i = 1; sda_i = 0;
    edges(3);
    chk("R6", "driven low", bus_loss, 1'b0);
    drv_bit = 1; scl_i = 0;
    edges(3);
    chk("R6", "scl low no compare", bus_loss, 1'b0);
    chk("R6", "no abort", abort_pulse, 1'b0);
    idle_all();
  endtask

  task automatic t_nack();
    nack_slot = 1; scl_i = 1; sda_i = 0;
    edges(1);
    chk("R7", "nack overridden", bus_loss, 1'b1);
    chk("R7", "abort", abort_pulse, 1'b1);
    nack_slot = 0; sda_i = 1;
    edges(2);
    chk("R9", "held before cmd", bus_loss, 1'b1);
    cmd_new = 1;
    edges(1);
    cmd_new = 0;
    chk("R9", "cleared by new command", bus_loss, 1'b0);
    idle_all();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    edges(1);
    t_reset();
    rst_n = 1;
    edges(1);
    t_reset();
    t_std_count();
    t_fast_count();
    t_restart();
    t_no_retry();
    t_tx_mismatch();
    t_low_bit();
    t_nack();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule